// File: doc/BRIEF.md
# Variable Partition Hole Allocator

The block keeps a small table of free memory regions ("holes"), each recorded as a base address and a length, and serves two kinds of request through a single-request handshake. An allocation asks for a number of bytes under a search policy chosen per request: the first hole that fits, the tightest fit, or the loosest fit. The block returns the base of the granted region and the byte count actually handed out. A release returns a region to the table. The region is fused with a free neighbour directly below it, directly above it, or both, so the table never holds two touching holes.

The table is walked one entry per clock. When a grant would leave a remainder too small to be worth tracking, the whole hole goes to the requester. The response then reports the larger size, and the excess is internal fragmentation for the caller to record. A request that cannot be met raises a fail flag and leaves the table as it was. An operating-system memory manager, or a hardware pool manager, issues one request, waits for the response pulse and then issues the next.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds a single hole at base 0 covering MEM_SIZE bytes, in slot 0, with every other slot empty; busy_o and rsp_valid_o are low.
- R2: A request is taken on a rising edge where req_valid_i is high and busy_o is low. busy_o is high from the next cycle until the response cycle. Requests presented while busy_o is high are ignored.
- R3: rsp_valid_o is a one-cycle pulse. Take the accepting edge as edge 0. The pulse is visible after edge N_HOLES+1, except for a first-fit allocation granted from slot k, whose pulse is visible after edge k+2.
- R4: Policy code 0 (and code 3, treated the same way) grants the lowest-index live hole whose size is at least the request, and stops the walk there.
- R5: Policy code 1 grants the smallest live hole that fits, and the lowest index among equal sizes.
- R6: Policy code 2 grants the largest live hole that fits, and the lowest index among equal sizes.
- R7: If the hole minus the request is at least MIN_FRAG, the granted size equals the request and the hole keeps the remainder, starting just above the granted region. Otherwise the whole hole is granted and rsp_size_o reports its full size. rsp_base_o is the hole's former base in both cases.
- R8: An allocation with size 0, or one that no live hole can satisfy, returns rsp_fail_o high and leaves the table unchanged.
- R9: A release merges with a live hole that ends exactly at its base and with one that starts exactly at its end, or with both. The result is a single hole, and the response reports that hole's base and size.
- R10: A release with no neighbour goes into the lowest-index empty slot and is reported as is. A release of size 0, or one with no neighbour and no empty slot, fails and leaves the table unchanged.
- R11: A hole that is granted entirely becomes an empty slot and is never granted again until it is refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_cmd_i | input | 1 | 0 = allocate, 1 = release |
| req_size_i | input | ADDR_W+1 | Byte count requested or released |
| req_base_i | input | ADDR_W | Base of the region being released |
| req_pol_i | input | 2 | Search policy: 0 first, 1 best, 2 worst, 3 first |
| busy_o | output | 1 | A request is being processed |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fail_o | output | 1 | Request could not be served |
| rsp_base_o | output | ADDR_W | Granted base, or base of the merged hole |
| rsp_size_o | output | ADDR_W+1 | Granted size, or size of the merged hole |

## Verification
Each result is due at a cycle the bench can compute. The pulse for a walk of the full table comes N_HOLES+1 edges after acceptance, and a first-fit hit in slot k answers after k+2 edges. The bench predicts the slot from its own model of the table. It counts edges from the accepting edge and compares the count with that prediction. It samples every output on the falling edge that follows. It also checks that the strobe is gone one cycle later, and it holds a conflicting request high during a busy cycle so that any effect shows up in later responses.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;
  typedef enum logic [0:0] {CMD_ALLOC = 1'b0, CMD_FREE = 1'b1} cmd_e;
  typedef enum logic [1:0] {POL_FIRST = 2'd0, POL_BEST = 2'd1, POL_WORST = 2'd2, POL_FIRST2 = 2'd3} pol_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SCAN = 2'd1, ST_DONE = 2'd2} st_e;
endpackage

// File: rtl/hole_alloc_table.sv
module hole_alloc_table #(
  parameter int N        = 4,
  parameter int AW       = 8,
  parameter int SW       = 9,
  parameter int IW       = 2,
  parameter int MEM_SIZE = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_base_o,
  output logic [SW-1:0] rd_size_o,
  input  logic          wr_a_en_i,
  input  logic [IW-1:0] wr_a_idx_i,
  input  logic          wr_a_valid_i,
  input  logic [AW-1:0] wr_a_base_i,
  input  logic [SW-1:0] wr_a_size_i,
  input  logic          wr_b_en_i,
  input  logic [IW-1:0] wr_b_idx_i
);
  logic          v_q [N];
  logic [AW-1:0] b_q [N];
  logic [SW-1:0] s_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        v_q[i] <= (i == 0);
        b_q[i] <= '0;
        s_q[i] <= (i == 0) ? SW'(MEM_SIZE) : '0;
      end
    end else begin
      if (wr_a_en_i) begin
        v_q[wr_a_idx_i] <= wr_a_valid_i;
        b_q[wr_a_idx_i] <= wr_a_base_i;
        s_q[wr_a_idx_i] <= wr_a_size_i;
      end
      // port b only retires a slot absorbed by a merge
      if (wr_b_en_i) begin
        v_q[wr_b_idx_i] <= 1'b0;
        s_q[wr_b_idx_i] <= '0;
      end
    end
  end

  assign rd_valid_o = v_q[rd_idx_i];
  assign rd_base_o  = b_q[rd_idx_i];
  assign rd_size_o  = s_q[rd_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_live
    assert_live_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q[g] |-> s_q[g] != '0);
  end

  assert_ports_disjoint_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a_en_i && wr_b_en_i) |-> wr_a_idx_i != wr_b_idx_i);
endmodule

// File: rtl/hole_alloc_scan.sv
module hole_alloc_scan
  import hole_alloc_pkg::*;
#(
  parameter int N        = 4,
  parameter int AW       = 8,
  parameter int SW       = 9,
  parameter int IW       = 2,
  parameter int MIN_FRAG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_cmd_i,
  input  logic [SW-1:0] req_size_i,
  input  logic [AW-1:0] req_base_i,
  input  logic [1:0]    req_pol_i,
  output logic          busy_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic          ent_valid_i,
  input  logic [AW-1:0] ent_base_i,
  input  logic [SW-1:0] ent_size_i,
  output logic          wr_a_en_o,
  output logic [IW-1:0] wr_a_idx_o,
  output logic          wr_a_valid_o,
  output logic [AW-1:0] wr_a_base_o,
  output logic [SW-1:0] wr_a_size_o,
  output logic          wr_b_en_o,
  output logic [IW-1:0] wr_b_idx_o,
  output logic          rsp_valid_o,
  output logic          rsp_fail_o,
  output logic [AW-1:0] rsp_base_o,
  output logic [SW-1:0] rsp_size_o
);
  localparam int EW = SW + 1;

  st_e           st_q;
  logic [IW-1:0] idx_q;
  cmd_e          cmd_q;
  pol_e          pol_q;
  logic [SW-1:0] rsz_q;
  logic [AW-1:0] rbase_q;

  logic          hit_q;
  logic [IW-1:0] hit_idx_q;
  logic [AW-1:0] hit_base_q;
  logic [SW-1:0] hit_size_q;
  logic          prev_q, next_q, empty_q;
  logic [IW-1:0] prev_idx_q, next_idx_q, empty_idx_q;
  logic [AW-1:0] prev_base_q;
  logic [SW-1:0] prev_size_q, next_size_q;

  logic          first_pol, fits, take, is_prev, is_next, last, stop;
  logic [EW-1:0] ent_end, req_end;

  assign first_pol = (pol_q == POL_FIRST) || (pol_q == POL_FIRST2);
  assign fits      = ent_valid_i && (rsz_q != '0) && (ent_size_i >= rsz_q);
  assign take      = fits && (!hit_q ||
                       ((pol_q == POL_BEST)  && (ent_size_i < hit_size_q)) ||
                       ((pol_q == POL_WORST) && (ent_size_i > hit_size_q)));
  assign ent_end   = EW'(ent_base_i) + EW'(ent_size_i);
  assign req_end   = EW'(rbase_q) + EW'(rsz_q);
  assign is_prev   = ent_valid_i && (ent_end == EW'(rbase_q));
  assign is_next   = ent_valid_i && (req_end == EW'(ent_base_i));
  assign last      = (idx_q == IW'(N - 1));
  assign stop      = last || ((cmd_q == CMD_ALLOC) && first_pol && take);

  assign busy_o   = (st_q != ST_IDLE);
  assign rd_idx_o = idx_q;

  // result of the finished walk, written to the table on the edge leaving DONE
  logic          res_fail;
  logic [AW-1:0] res_base;
  logic [SW-1:0] res_size;
  logic [SW-1:0] left;

  always_comb begin
    res_fail     = 1'b0;
    res_base     = '0;
    res_size     = '0;
    left         = hit_size_q - rsz_q;
    wr_a_en_o    = 1'b0;
    wr_a_idx_o   = '0;
    wr_a_valid_o = 1'b0;
    wr_a_base_o  = '0;
    wr_a_size_o  = '0;
    wr_b_en_o    = 1'b0;
    wr_b_idx_o   = '0;
    if (st_q == ST_DONE) begin
      if (cmd_q == CMD_ALLOC) begin
        if (!hit_q) begin
          res_fail = 1'b1;
        end else begin
          res_base   = hit_base_q;
          wr_a_en_o  = 1'b1;
          wr_a_idx_o = hit_idx_q;
          if (left < SW'(MIN_FRAG)) begin
            res_size = hit_size_q;
          end else begin
            res_size     = rsz_q;
            wr_a_valid_o = 1'b1;
            wr_a_base_o  = hit_base_q + AW'(rsz_q);
            wr_a_size_o  = left;
          end
        end
      end else begin
        if (rsz_q == '0) begin
          res_fail = 1'b1;
        end else if (prev_q) begin
          res_base     = prev_base_q;
          res_size     = prev_size_q + rsz_q + (next_q ? next_size_q : '0);
          wr_a_en_o    = 1'b1;
          wr_a_idx_o   = prev_idx_q;
          wr_a_valid_o = 1'b1;
          wr_a_base_o  = prev_base_q;
          wr_a_size_o  = res_size;
          wr_b_en_o    = next_q;
          wr_b_idx_o   = next_idx_q;
        end else if (next_q) begin
          res_base     = rbase_q;
          res_size     = next_size_q + rsz_q;
          wr_a_en_o    = 1'b1;
          wr_a_idx_o   = next_idx_q;
          wr_a_valid_o = 1'b1;
          wr_a_base_o  = rbase_q;
          wr_a_size_o  = res_size;
        end else if (empty_q) begin
          res_base     = rbase_q;
          res_size     = rsz_q;
          wr_a_en_o    = 1'b1;
          wr_a_idx_o   = empty_idx_q;
          wr_a_valid_o = 1'b1;
          wr_a_base_o  = rbase_q;
          wr_a_size_o  = rsz_q;
        end else begin
          res_fail = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      cmd_q       <= CMD_ALLOC;
      pol_q       <= POL_FIRST;
      rsz_q       <= '0;
      rbase_q     <= '0;
      hit_q       <= 1'b0;
      hit_idx_q   <= '0;
      hit_base_q  <= '0;
      hit_size_q  <= '0;
      prev_q      <= 1'b0;
      next_q      <= 1'b0;
      empty_q     <= 1'b0;
      prev_idx_q  <= '0;
      next_idx_q  <= '0;
      empty_idx_q <= '0;
      prev_base_q <= '0;
      prev_size_q <= '0;
      next_size_q <= '0;
      rsp_valid_o <= 1'b0;
      rsp_fail_o  <= 1'b0;
      rsp_base_o  <= '0;
      rsp_size_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            st_q    <= ST_SCAN;
            idx_q   <= '0;
            cmd_q   <= cmd_e'(req_cmd_i);
            pol_q   <= pol_e'(req_pol_i);
            rsz_q   <= req_size_i;
            rbase_q <= req_base_i;
            hit_q   <= 1'b0;
            prev_q  <= 1'b0;
            next_q  <= 1'b0;
            empty_q <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (cmd_q == CMD_ALLOC) begin
            if (take) begin
              hit_q      <= 1'b1;
              hit_idx_q  <= idx_q;
              hit_base_q <= ent_base_i;
              hit_size_q <= ent_size_i;
            end
          end else begin
            if (is_prev) begin
              prev_q      <= 1'b1;
              prev_idx_q  <= idx_q;
              prev_base_q <= ent_base_i;
              prev_size_q <= ent_size_i;
            end
            if (is_next) begin
              next_q      <= 1'b1;
              next_idx_q  <= idx_q;
              next_size_q <= ent_size_i;
            end
            if (!ent_valid_i && !empty_q) begin
              empty_q     <= 1'b1;
              empty_idx_q <= idx_q;
            end
          end
          idx_q <= idx_q + 1'b1;
          if (stop) st_q <= ST_DONE;
        end
        ST_DONE: begin
          st_q        <= ST_IDLE;
          rsp_valid_o <= 1'b1;
          rsp_fail_o  <= res_fail;
          rsp_base_o  <= res_base;
          rsp_size_o  <= res_size;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_grant_covers_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fail_o && cmd_q == CMD_ALLOC) |->
      (rsp_size_o >= rsz_q) && ((rsp_size_o - rsz_q) < SW'(MIN_FRAG)));

  assert_first_fit_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN && cmd_q == CMD_ALLOC && first_pol) |-> !hit_q);

  assert_fail_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fail_o) |-> $past(!wr_a_en_o && !wr_b_en_o));

  assert_zero_alloc_fails_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && cmd_q == CMD_ALLOC && rsz_q == '0) |-> rsp_fail_o);
endmodule

// File: rtl/hole_alloc.sv
module hole_alloc #(
  parameter int N_HOLES  = 4,
  parameter int ADDR_W   = 8,
  parameter int MEM_SIZE = 240,
  parameter int MIN_FRAG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_cmd_i,
  input  logic [ADDR_W:0]   req_size_i,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [1:0]        req_pol_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_fail_o,
  output logic [ADDR_W-1:0] rsp_base_o,
  output logic [ADDR_W:0]   rsp_size_o
);
  localparam int IW = (N_HOLES > 1) ? $clog2(N_HOLES) : 1;
  localparam int SW = ADDR_W + 1;

  logic [IW-1:0]     rd_idx;
  logic              ent_valid;
  logic [ADDR_W-1:0] ent_base;
  logic [SW-1:0]     ent_size;
  logic              wr_a_en, wr_a_valid, wr_b_en;
  logic [IW-1:0]     wr_a_idx, wr_b_idx;
  logic [ADDR_W-1:0] wr_a_base;
  logic [SW-1:0]     wr_a_size;

  hole_alloc_scan #(
    .N(N_HOLES), .AW(ADDR_W), .SW(SW), .IW(IW), .MIN_FRAG(MIN_FRAG)
  ) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_cmd_i    (req_cmd_i),
    .req_size_i   (req_size_i),
    .req_base_i   (req_base_i),
    .req_pol_i    (req_pol_i),
    .busy_o       (busy_o),
    .rd_idx_o     (rd_idx),
    .ent_valid_i  (ent_valid),
    .ent_base_i   (ent_base),
    .ent_size_i   (ent_size),
    .wr_a_en_o    (wr_a_en),
    .wr_a_idx_o   (wr_a_idx),
    .wr_a_valid_o (wr_a_valid),
    .wr_a_base_o  (wr_a_base),
    .wr_a_size_o  (wr_a_size),
    .wr_b_en_o    (wr_b_en),
    .wr_b_idx_o   (wr_b_idx),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_fail_o   (rsp_fail_o),
    .rsp_base_o   (rsp_base_o),
    .rsp_size_o   (rsp_size_o)
  );

  hole_alloc_table #(
    .N(N_HOLES), .AW(ADDR_W), .SW(SW), .IW(IW), .MEM_SIZE(MEM_SIZE)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (rd_idx),
    .rd_valid_o   (ent_valid),
    .rd_base_o    (ent_base),
    .rd_size_o    (ent_size),
    .wr_a_en_i    (wr_a_en),
    .wr_a_idx_i   (wr_a_idx),
    .wr_a_valid_i (wr_a_valid),
    .wr_a_base_i  (wr_a_base),
    .wr_a_size_i  (wr_a_size),
    .wr_b_en_i    (wr_b_en),
    .wr_b_idx_i   (wr_b_idx)
  );

  assert_rsp_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(busy_o) && !busy_o));

  assert_rsp_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/hole_alloc_bench.sv
module hole_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int AW   = 8;
  localparam int SW   = 9;
  localparam int MEM  = 240;
  localparam int MINF = 4;

  logic clk, rst_n;
  logic req_valid, req_cmd;
  logic [SW-1:0] req_size;
  logic [AW-1:0] req_base;
  logic [1:0] req_pol;
  logic busy, rsp_valid, rsp_fail;
  logic [AW-1:0] rsp_base;
  logic [SW-1:0] rsp_size;

  hole_alloc #(.N_HOLES(N), .ADDR_W(AW), .MEM_SIZE(MEM), .MIN_FRAG(MINF)) u_hole_alloc (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_size_i(req_size), .req_base_i(req_base), .req_pol_i(req_pol),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_fail_o(rsp_fail),
    .rsp_base_o(rsp_base), .rsp_size_o(rsp_size)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0;
  int mv [N], mb [N], ms [N];   // reference table
  int lb [16], ls [16], ln;      // live grants
  int unsigned rng = 32'h1234_5679;

  function automatic int unsigned rnd();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input bit cmd, input int size, input int base, input int pol, input bit hold,
                        output bit f, output int rb, output int rs, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_size = SW'(size); req_base = AW'(base); req_pol = 2'(pol);
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
      req_cmd = ~cmd; req_size = 9'd3; req_base = 8'd7; req_pol = 2'd2;
    end else req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 1) req_valid = 1'b0;
    end while (!rsp_valid && lat < 40);
    f = rsp_fail; rb = int'(rsp_base); rs = int'(rsp_size);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3", "strobe lasts one cycle", int'(rsp_valid), 0);
  endtask

  task automatic do_alloc(input int size, input int pol, input bit hold, output bit ef, output int gb, output int gs);
    int hit = -1; int el; bit f; int rb, rs, lat; string pt;
    for (int i = 0; i < N; i++)
      if (mv[i] != 0 && size > 0 && ms[i] >= size) begin
        if (pol == 1) begin if (hit < 0 || ms[i] < ms[hit]) hit = i; end
        else if (pol == 2) begin if (hit < 0 || ms[i] > ms[hit]) hit = i; end
        else if (hit < 0) hit = i;
      end
    pt = (pol == 1) ? "R5" : (pol == 2) ? "R6" : "R4";
    el = (hit >= 0 && (pol == 0 || pol == 3)) ? hit + 2 : N + 1;
    ef = (hit < 0); gb = 0; gs = 0;
    if (!ef) begin
      gb = mb[hit];
      if (ms[hit] - size < MINF) begin gs = ms[hit]; mv[hit] = 0; ms[hit] = 0; end
      else begin gs = size; mb[hit] += size; ms[hit] -= size; end
    end
    run_op(1'b0, size, 0, pol, hold, f, rb, rs, lat);
    chk(f == ef, ef ? "R8" : pt, "alloc fail flag", int'(f), int'(ef));
    if (!ef) begin
      chk(rb == gb, pt, "granted base", rb, gb);
      chk(rs == gs, "R7", "granted size", rs, gs);
      if (ln < 16) begin lb[ln] = gb; ls[ln] = gs; ln++; end
    end
    chk(lat == el, "R3", "alloc latency", lat, el);
  endtask

  task automatic do_free(input int base, input int size, input bit hold, output bit ef);
    int p = -1, n = -1, e = -1; bit f; int rb, rs, lat, eb, es; string t;
    for (int i = 0; i < N; i++) begin
      if (mv[i] != 0 && mb[i] + ms[i] == base) p = i;
      if (mv[i] != 0 && base + size == mb[i]) n = i;
      if (mv[i] == 0 && e < 0) e = i;
    end
    t = (p >= 0 || n >= 0) ? "R9" : "R10";
    ef = 1'b0; eb = 0; es = 0;
    if (size == 0) ef = 1'b1;
    else if (p >= 0) begin
      eb = mb[p]; es = ms[p] + size;
      if (n >= 0) begin es += ms[n]; mv[n] = 0; ms[n] = 0; end
      ms[p] = es;
    end else if (n >= 0) begin
      eb = base; es = ms[n] + size; mb[n] = base; ms[n] = es;
    end else if (e >= 0) begin
      eb = base; es = size; mv[e] = 1; mb[e] = base; ms[e] = size;
    end else ef = 1'b1;
    if (size == 0) t = "R10";
    run_op(1'b1, size, base, 0, hold, f, rb, rs, lat);
    chk(f == ef, t, "release fail flag", int'(f), int'(ef));
    if (!ef) begin
      chk(rb == eb, t, "resulting hole base", rb, eb);
      chk(rs == es, t, "resulting hole size", rs, es);
      for (int j = 0; j < ln; j++)
        if (lb[j] == base && ls[j] == size) begin
          lb[j] = lb[ln-1]; ls[j] = ls[ln-1]; ln--; break;
        end
    end
    chk(lat == N + 1, "R3", "release latency", lat, N + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit f; int gb, gs;
    req_valid = 0; req_cmd = 0; req_size = '0; req_base = '0; req_pol = '0;
    ln = 0;
    for (int i = 0; i < N; i++) begin mv[i] = (i == 0); mb[i] = 0; ms[i] = (i == 0) ? MEM : 0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    rst_n = 1'b1;

    // R1 full hole, R7 remainder 3 < MINF so whole hole goes
    do_alloc(237, 0, 1'b0, f, gb, gs);
    chk(gs == MEM, "R7", "whole hole absorbed", gs, MEM);
    // R11 consumed hole is skipped
    do_alloc(1, 1, 1'b0, f, gb, gs);
    chk(f == 1'b1, "R11", "empty slot not granted", int'(f), 1);
    do_free(0, 240, 1'b0, f);            // R10 into empty slot
    do_alloc(236, 1, 1'b0, f, gb, gs);   // R7 remainder 4 kept
    do_free(0, 236, 1'b0, f);            // R9 merge with following hole
    do_free(5, 0, 1'b0, f);              // R10 zero size fails
    do_alloc(0, 2, 1'b0, f, gb, gs);     // R8 zero size fails
    do_alloc(241, 2, 1'b0, f, gb, gs);   // R8 nothing fits

    // equal-size holes for tie breaking (R5, R6)
    for (int k = 0; k < 4; k++) do_alloc(40, 0, 1'b0, f, gb, gs);
    do_free(0, 40, 1'b0, f);
    do_free(80, 40, 1'b1, f);            // R2 request while busy ignored
    do_alloc(30, 1, 1'b0, f, gb, gs);
    do_alloc(30, 2, 1'b0, f, gb, gs);
    do_alloc(5, 3, 1'b1, f, gb, gs);
    do_alloc(8, 0, 1'b0, f, gb, gs);

    for (int it = 0; it < 600; it++) begin
      int r = int'(rnd() % 8);
      bit hold = (rnd() % 8) == 0;
      if (ln > 0 && (r < 3 || ln >= 16)) begin
        int j = int'(rnd() % ln);
        do_free(lb[j], ls[j], hold, f);
      end else if (r == 3) begin
        do_alloc(0, int'(rnd() % 4), hold, f, gb, gs);
      end else begin
        do_alloc(1 + int'(rnd() % 70), int'(rnd() % 4), hold, f, gb, gs);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule